// File: doc/BRIEF.md
# Bidirectional Serial Sample Delay Line

This block sits on the serial sample link between a sub-band filter and a codec and holds every stereo sample pair back by a fixed number of word-select periods before passing it on. The link carries one word-select signal at the sample rate and a bit clock at 64 times that rate. Each word-select period holds one 24-bit left sample and one 24-bit right sample. The block splits each incoming period into its two samples, stores the pair in a ring, and later sends the pair back out in the same serial framing on the opposite data pin.

The direction is set once for each reset. In encode direction, samples enter on the filter-side pin and leave on the codec-side pin after the long delay. In decode direction, samples enter on the codec-side pin and leave on the filter-side pin after the short delay. A frame-sync flag that marks sub-band 0 travels through the same ring, so it stays aligned with the delayed samples. Each data pin has an output enable, so that a pad ring can build the bidirectional pins from it. The bit clock is the block's clock: the block captures on the rising edge and launches on the falling edge.

Top module: `fi2s_delay_line`

## Requirements
- R1: A word-select period has 64 bit-clock slots. Slots 0 to 31 carry the left channel with `sws` low, and slots 32 to 63 carry the right channel with `sws` high. In each half, half-slots 1 to 24 carry the 24-bit sample MSB first, so half-slot 1 holds bit 23. The block ignores the input level in every other slot. The output uses the same framing and changes on falling bit-clock edges.
- R2: If `dir_sel` is 0 when `frst` falls (encode), the pair that enters on `filt_din` in period p leaves on `cod_dout` in period p+480.
- R3: If `dir_sel` is 1 when `frst` falls (decode), the pair that enters on `cod_din` in period p leaves on `filt_dout` in period p+160.
- R4: The direction follows `dir_sel` only while `frst` is high. Changes on `dir_sel` after `frst` falls have no effect on which pin receives and which pin sends.
- R5: Numbering the first complete period after reset as 0, every output period before the delay count carries all-zero samples and a low frame-sync output.
- R6: On the sending pin, the output enable is high exactly in half-slots 1 to 24 of each half. The enable of the receiving pin stays low.
- R7: The level of `fsync_in` in left half-slot 24 of period p appears on `fsync_out` throughout the left half of output period p+delay. `fsync_out` is low in every right half.
- R8: `frst` high acts as a general reset. Both output enables and `fsync_out` go low, and the ring is marked empty again, so the zero fill of R5 applies after every reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Bit clock, 64 times the sample rate; rising edge captures, falling edge launches |
| sws | input | 1 | Word select: low for the left half, high for the right half |
| frst | input | 1 | Synchronous general reset, active high; direction latched as it falls |
| dir_sel | input | 1 | Direction request: 0 encode, 1 decode |
| fsync_in | input | 1 | Frame-sync flag marking the period that carries sub-band 0 |
| filt_din | input | 1 | Filter-side serial data in |
| cod_din | input | 1 | Codec-side serial data in |
| filt_dout | output | 1 | Filter-side serial data out (decode direction) |
| filt_oe | output | 1 | Filter-side output enable |
| cod_dout | output | 1 | Codec-side serial data out (encode direction) |
| cod_oe | output | 1 | Codec-side output enable |
| fsync_out | output | 1 | Delayed frame-sync flag, valid in left halves |

## Verification
The hardest state to reach from the ports is the wrap of the 480-period ring. Until the ring has wrapped, the block must send zeros. After the wrap it must return the pair stored exactly 480 periods earlier, with its sync flag. The bench drives more than 480 complete periods of random pairs, with corner words and random levels in the non-data slots, so it passes through the last zero period and the first delayed one. Then it resets into decode direction while the ring still holds encode data. This checks that the zero fill returns after the reset and that the shorter wrap takes effect. During this run `dir_sel` toggles randomly.

// File: rtl/fi2s_pkg.sv
package fi2s_pkg;

    localparam int unsigned SMP_W      = 24;
    localparam int unsigned HALF_SLOTS = 32;
    localparam int unsigned SLOT_W     = $clog2(HALF_SLOTS);

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic {
        DIR_ENC = 1'b0,
        DIR_DEC = 1'b1
    } dir_e;

    typedef struct packed {
        logic             sync;
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } frame_t;

    // half-slot carries a sample bit
    function automatic logic slot_has_data(input slot_t idx);
        return (idx >= slot_t'(1)) && (idx <= slot_t'(SMP_W));
    endfunction

    // half-slot position of the bit captured at the next rising edge
    function automatic slot_t next_slot(input slot_t cur, input logic edge_seen);
        if (edge_seen)
            return '0;
        if (cur == slot_t'(HALF_SLOTS - 1))
            return cur;
        return slot_t'(cur + 1'b1);
    endfunction

endpackage

// File: rtl/fi2s_framer.sv
module fi2s_framer
    import fi2s_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sws,
    input  logic   din,
    input  logic   fsync_in,
    output slot_t  slot_q,
    output logic   half_q,
    output frame_t frame_o,
    output logic   frame_wr
);

    logic [SMP_W-1:0] shreg;
    logic [SMP_W-1:0] left_hold;
    logic [SMP_W-1:0] word_n;
    logic             sync_hold;
    logic             left_seen;
    logic             edge_seen;
    slot_t            slot_n;

    always_comb begin
        edge_seen = (sws != half_q);
        slot_n    = next_slot(slot_q, edge_seen);
        word_n    = {shreg[SMP_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q    <= 1'b1;
            slot_q    <= '1;
            shreg     <= '0;
            left_hold <= '0;
            sync_hold <= 1'b0;
            left_seen <= 1'b0;
            frame_wr  <= 1'b0;
            frame_o   <= '0;
        end else begin
            half_q   <= sws;
            slot_q   <= slot_n;
            frame_wr <= 1'b0;
            if (slot_has_data(slot_n))
                shreg <= word_n;
            if (slot_n == slot_t'(SMP_W)) begin
                if (!sws) begin
                    left_hold <= word_n;
                    sync_hold <= fsync_in;
                    left_seen <= 1'b1;
                end else if (left_seen) begin
                    frame_o  <= '{sync: sync_hold, left: left_hold, right: word_n};
                    frame_wr <= 1'b1;
                end
            end
        end
    end

    // one stored pair per word-select period
    assert_single_write_R1: assert property (@(posedge clk) disable iff (rst)
        frame_wr |=> !frame_wr);

endmodule

// File: rtl/fi2s_ring.sv
module fi2s_ring
    import fi2s_pkg::*;
#(
    parameter int unsigned ENC_DEPTH = 480,
    parameter int unsigned DEC_DEPTH = 160
) (
    input  logic   clk,
    input  logic   rst,
    input  dir_e   mode,
    input  logic   wr_en,
    input  frame_t wr_frame,
    output frame_t rd_frame
);

    localparam int unsigned MAX_D = (ENC_DEPTH > DEC_DEPTH) ? ENC_DEPTH : DEC_DEPTH;
    localparam int unsigned RING  = MAX_D - 1;
    localparam int unsigned PTR_W = (RING > 1) ? $clog2(RING) : 1;

    typedef logic [PTR_W-1:0] ptr_t;

    localparam ptr_t ENC_LAST = ptr_t'(ENC_DEPTH - 2);
    localparam ptr_t DEC_LAST = ptr_t'(DEC_DEPTH - 2);

    frame_t ring_mem [RING];
    ptr_t   ptr;
    ptr_t   last;
    logic   filled;

    assign last = (mode == DIR_DEC) ? DEC_LAST : ENC_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            filled   <= 1'b0;
            rd_frame <= '0;
        end else if (wr_en) begin
            rd_frame <= filled ? ring_mem[ptr] : '0;
            if (ptr == last) begin
                ptr    <= '0;
                filled <= 1'b1;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            ring_mem[ptr] <= wr_frame;
    end

    assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (rst)
        ptr <= last);

    // the ring is marked full only on its first wrap
    assert_fill_on_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(filled) |-> (ptr == '0));

endmodule

// File: rtl/fi2s_serializer.sv
module fi2s_serializer
    import fi2s_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  slot_t  slot_q,
    input  logic   half_q,
    input  frame_t obuf,
    output logic   dout,
    output logic   oe,
    output logic   fsync_out
);

    slot_t            out_slot;
    slot_t            bsel;
    logic             out_half;
    logic             has;
    logic [SMP_W-1:0] word;

    always_comb begin
        if (slot_q == slot_t'(HALF_SLOTS - 1)) begin
            out_half = ~half_q;
            out_slot = '0;
        end else begin
            out_half = half_q;
            out_slot = slot_t'(slot_q + 1'b1);
        end
        has  = slot_has_data(out_slot);
        bsel = slot_t'(SMP_W) - out_slot;
        word = out_half ? obuf.right : obuf.left;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            dout      <= 1'b0;
            oe        <= 1'b0;
            fsync_out <= 1'b0;
        end else begin
            oe        <= has;
            dout      <= has ? word[bsel] : 1'b0;
            fsync_out <= obuf.sync & ~out_half;
        end
    end

    // enable ends right after the last sample bit of a half
    assert_oe_window_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(oe) |-> (slot_q == slot_t'(SMP_W)));

endmodule

// File: rtl/fi2s_delay_line.sv
module fi2s_delay_line
    import fi2s_pkg::*;
#(
    parameter int unsigned ENC_DELAY = 480,
    parameter int unsigned DEC_DELAY = 160
) (
    input  logic sck,
    input  logic sws,
    input  logic frst,
    input  logic dir_sel,
    input  logic fsync_in,
    input  logic filt_din,
    input  logic cod_din,
    output logic filt_dout,
    output logic filt_oe,
    output logic cod_dout,
    output logic cod_oe,
    output logic fsync_out
);

    dir_e   mode;
    logic   rst_q;
    logic   din_sel;
    slot_t  slot_q;
    logic   half_q;
    frame_t wr_frame;
    logic   wr_en;
    frame_t obuf;
    logic   ser_d;
    logic   ser_oe;

    always_ff @(posedge sck) begin
        rst_q <= frst;
        if (frst)
            mode <= dir_e'(dir_sel);
    end

    assign din_sel = (mode == DIR_DEC) ? cod_din : filt_din;

    fi2s_framer u_framer (
        .clk      (sck),
        .rst      (frst),
        .sws      (sws),
        .din      (din_sel),
        .fsync_in (fsync_in),
        .slot_q   (slot_q),
        .half_q   (half_q),
        .frame_o  (wr_frame),
        .frame_wr (wr_en)
    );

    fi2s_ring #(
        .ENC_DEPTH (ENC_DELAY),
        .DEC_DEPTH (DEC_DELAY)
    ) u_ring (
        .clk      (sck),
        .rst      (frst),
        .mode     (mode),
        .wr_en    (wr_en),
        .wr_frame (wr_frame),
        .rd_frame (obuf)
    );

    fi2s_serializer u_ser (
        .clk       (sck),
        .rst       (rst_q),
        .slot_q    (slot_q),
        .half_q    (half_q),
        .obuf      (obuf),
        .dout      (ser_d),
        .oe        (ser_oe),
        .fsync_out (fsync_out)
    );

    always_comb begin
        filt_dout = (mode == DIR_DEC) ? ser_d : 1'b0;
        filt_oe   = (mode == DIR_DEC) & ser_oe;
        cod_dout  = (mode == DIR_ENC) ? ser_d : 1'b0;
        cod_oe    = (mode == DIR_ENC) & ser_oe;
    end

    assert_mode_hold_R4: assert property (@(posedge sck) disable iff (frst)
        !frst |=> $stable(mode));

endmodule

// File: tb/tb_fi2s_delay_line.sv
module tb_fi2s_delay_line;

    localparam int CLK_PERIOD = 10;
    localparam int ENC_D      = 480;
    localparam int DEC_D      = 160;
    localparam int EXTRA      = 8;
    localparam int MAXP       = ENC_D + EXTRA;

    logic sck = 1'b0;
    logic sws = 1'b1, frst = 1'b1, dir_sel = 1'b0, fsync_in = 1'b0;
    logic filt_din = 1'b0, cod_din = 1'b0;
    logic filt_dout, filt_oe, cod_dout, cod_oe, fsync_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [23:0] lw [MAXP];
    logic [23:0] rw [MAXP];
    logic        sy [MAXP];

    always #(CLK_PERIOD/2) sck = ~sck;

    fi2s_delay_line #(.ENC_DELAY(ENC_D), .DEC_DELAY(DEC_D)) dut (
        .sck(sck), .sws(sws), .frst(frst), .dir_sel(dir_sel), .fsync_in(fsync_in),
        .filt_din(filt_din), .cod_din(cod_din),
        .filt_dout(filt_dout), .filt_oe(filt_oe),
        .cod_dout(cod_dout), .cod_oe(cod_oe), .fsync_out(fsync_out)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] pick_word(input int p, input int salt);
        case (p)
            3:       return 24'hFFFFFF;
            4:       return 24'h800000;
            5:       return 24'h000001;
            6:       return 24'h000000;
            default: return 24'($urandom()) ^ 24'(salt);
        endcase
    endfunction

    task automatic run_mode(input logic dir, input int nd, input int np, input bit toggle);
        string dtag;
        dtag = dir ? "R3" : "R2";
        for (int p = 0; p < np; p++) begin
            lw[p] = pick_word(p, 0);
            rw[p] = pick_word(p, 24'h5A5A5A);
            sy[p] = ((p % 32) == 2);
        end
        // general reset with direction request
        @(negedge sck);
        frst = 1'b1; dir_sel = dir; sws = 1'b1; fsync_in = 1'b0;
        repeat (4) @(negedge sck);
        @(posedge sck); #1;
        check("R8", "filt_oe in reset", {31'd0, filt_oe}, 32'd0);
        check("R8", "cod_oe in reset", {31'd0, cod_oe}, 32'd0);
        check("R8", "fsync_out in reset", {31'd0, fsync_out}, 32'd0);
        @(negedge sck);
        frst = 1'b0;
        repeat (3) @(posedge sck);
        for (int q = 0; q < np; q++) begin
            logic [23:0] gl, gr, el, er;
            int oe_bad, side_bad, sync_bad;
            gl = '0; gr = '0; oe_bad = 0; side_bad = 0; sync_bad = 0;
            for (int k = 0; k < 64; k++) begin
                int h;
                logic b, rx_d, rx_oe, tx_oe, es;
                h = k % 32;
                @(negedge sck);
                sws = (k >= 32);
                if (h >= 1 && h <= 24)
                    b = (k < 32) ? lw[q][24-h] : rw[q][24-h];
                else
                    b = 1'($urandom());
                if (dir) begin
                    cod_din = b; filt_din = 1'($urandom());
                end else begin
                    filt_din = b; cod_din = 1'($urandom());
                end
                fsync_in = sy[q] && (k < 32);
                if (toggle)
                    dir_sel = 1'($urandom());
                @(posedge sck); #1;
                rx_d  = dir ? filt_dout : cod_dout;
                rx_oe = dir ? filt_oe : cod_oe;
                tx_oe = dir ? cod_oe : filt_oe;
                if (h >= 1 && h <= 24) begin
                    if (rx_oe !== 1'b1) oe_bad++;
                    if (k < 32) gl = {gl[22:0], rx_d};
                    else        gr = {gr[22:0], rx_d};
                end else if (rx_oe !== 1'b0) begin
                    oe_bad++;
                end
                if (tx_oe !== 1'b0) side_bad++;
                es = (q >= nd) && sy[q-nd] && (k < 32);
                if (fsync_out !== es) sync_bad++;
            end
            el = (q >= nd) ? lw[q-nd] : 24'd0;
            er = (q >= nd) ? rw[q-nd] : 24'd0;
            if (q < nd) begin
                check(dir ? "R5 R8" : "R5", "zero-fill left", {8'd0, gl}, {8'd0, el});
                check(dir ? "R5 R8" : "R5", "zero-fill right", {8'd0, gr}, {8'd0, er});
            end else begin
                check(dtag, "R1 delayed left", {8'd0, gl}, {8'd0, el});
                check(dtag, "R1 delayed right", {8'd0, gr}, {8'd0, er});
            end
            check("R6", "enable slot errors", 32'(oe_bad), 32'd0);
            check(toggle ? "R4 R6" : "R6", "receive-side enable", 32'(side_bad), 32'd0);
            check("R7", "fsync mismatches", 32'(sync_bad), 32'd0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'h1F25));
        run_mode(1'b0, ENC_D, ENC_D + EXTRA, 1'b0);
        run_mode(1'b1, DEC_D, DEC_D + EXTRA, 1'b1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge sck);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule